// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block is the first stage of a five-stage load/store pipeline. It holds the program counter and drives the instruction-memory address. At every clock edge it captures the returned instruction word into the fetch-to-decode instruction register (IR2). It also captures the incremented program counter into the fetch-to-decode PC register (PC2).

The decode stage sends back a branch-class flag, a 3-bit condition code and two register values. One register value is the tested operand. The other is the jump target. When the flag is set and the code's test on the operand holds, the next PC is the target register, with its byte-offset bits cleared. Otherwise the PC advances by one word. The redirect takes effect at the next edge. The word fetched in the same cycle still enters IR2, so the pipeline has one branch delay slot.

The memory answers combinationally within the cycle in which the address is presented. The unit registers that word at the closing edge.

Top module: `ifu_top`

## Requirements
- R1: While `rst_n` is low, `imem_addr_o` is 0, `ir2_o` holds the no-op word (default 32'h0000_0000) and `pc2_o` is 0. The reset acts without waiting for a clock edge.
- R2: `imem_addr_o` always equals the current PC, and its two low bits are always zero.
- R3: When no branch is taken, the PC advances by exactly 4 at each clock edge.
- R4: At each clock edge, `ir2_o` takes the value of `imem_rdata_i` and `pc2_o` takes the current fetch address plus 4.
- R5: A taken branch loads the PC at the next edge with `rb_val_i`, its bits [1:0] forced to zero.
- R6: With `br_class_i` low, no condition code causes a redirect.
- R7: Condition code 0 never branches.
- R8: Condition code 1 always branches.
- R9: Code 2 branches when `rc_val_i` is zero. Code 3 branches when `rc_val_i` is nonzero.
- R10: Code 4 branches when bit 31 of `rc_val_i` is 0 (non-negative). Code 5 branches when that bit is 1 (negative).
- R11: Codes 6 and 7 never branch.
- R12: The word fetched in the cycle a branch is taken still enters IR2 at that edge (delay slot). The target's word follows at the next edge, with `pc2_o` equal to the target plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| br_class_i | input | 1 | Decode stage holds a conditional-branch instruction |
| cond_code_i | input | 3 | Condition code of that branch |
| rc_val_i | input | 32 | Register value tested by the condition |
| rb_val_i | input | 32 | Register value used as the branch target |
| imem_rdata_i | input | 32 | Instruction word read at `imem_addr_o` |
| imem_addr_o | output | 32 | Instruction-memory byte address (the PC) |
| ir2_o | output | 32 | Fetched instruction for the decode stage |
| pc2_o | output | 32 | Fetch address plus 4 for the decode stage |

## Verification
The bench probes both sides of every condition code. It uses a zero operand, the most negative value and all-ones. A sign test that looks at the wrong bit, or a zero test that is inverted, then sends the PC to the target instead of stepping by 4, or the reverse. It also tries a target with its low bits set, which catches a design that fetches from an unaligned address. It tries codes 6 and 7 and a cleared branch flag, which catch a design that decodes only the low code bits. Finally it follows a taken branch over two edges. A design that squashed the slot or delayed the redirect would put the wrong word into IR2 or the wrong value into PC2.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [2:0] {
    CC_NEVER   = 3'd0,
    CC_ALWAYS  = 3'd1,
    CC_ZERO    = 3'd2,
    CC_NONZERO = 3'd3,
    CC_NONNEG  = 3'd4,
    CC_NEG     = 3'd5
  } cond_code_e;

  localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/ifu_cond_eval.sv
module ifu_cond_eval
  import ifu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              branch_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   rc_i,
  output logic              take_o
);
  logic is_zero;
  logic is_neg;
  logic cond_met;

  assign is_zero = (rc_i == '0);
  assign is_neg  = rc_i[XLEN-1];

  always_comb begin
    case (code_i)
      CC_ALWAYS:  cond_met = 1'b1;
      CC_ZERO:    cond_met = is_zero;
      CC_NONZERO: cond_met = !is_zero;
      CC_NONNEG:  cond_met = !is_neg;
      CC_NEG:     cond_met = is_neg;
      default:    cond_met = 1'b0;
    endcase
  end

  assign take_o = branch_i & cond_met;

  always_comb begin
    if (!branch_i) begin
      assert_flag_gates_R6: assert (!take_o);
    end
    if (code_i == CC_NEVER || code_i == 3'd6 || code_i == 3'd7) begin
      assert_dead_codes_R11: assert (!take_o);
    end
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_inc_o
);
  localparam logic [XLEN-1:0] STEP_V     = XLEN'(STEP);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(STEP - 1));

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    pc_inc_o = pc_q + STEP_V;
    pc_en    = 1'b1;
    if (take_i) begin
      pc_d = target_i & ALIGN_MASK;
    end else begin
      pc_d = pc_inc_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q & ~ALIGN_MASK) == '0);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> pc_q == $past(pc_q) + STEP_V);

  assert_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> pc_q == ($past(target_i) & ALIGN_MASK));
endmodule

// File: rtl/ifu_ir_stage.sv
module ifu_ir_stage #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en_i,
  input  logic [XLEN-1:0] word_i,
  input  logic [XLEN-1:0] pc_inc_i,
  output logic [XLEN-1:0] ir2_o,
  output logic [XLEN-1:0] pc2_o
);
  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] pc2_q, pc2_d;

  always_comb begin
    ir_d  = ir_q;
    pc2_d = pc2_q;
    if (load_en_i) begin
      ir_d  = word_i;
      pc2_d = pc_inc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= NOP_WORD;
      pc2_q <= '0;
    end else begin
      ir_q  <= ir_d;
      pc2_q <= pc2_d;
    end
  end

  assign ir2_o = ir_q;
  assign pc2_o = pc2_q;

  assert_ir_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> ir_q == $past(word_i));

  assert_pc2_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> pc2_q == $past(pc_inc_i));
endmodule

// File: rtl/ifu_top.sv
module ifu_top
  import ifu_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     STEP     = 4,
  parameter logic [XLEN-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_class_i,
  input  logic [CODE_W-1:0] cond_code_i,
  input  logic [XLEN-1:0]   rc_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [XLEN-1:0]   imem_rdata_i,
  output logic [XLEN-1:0]   imem_addr_o,
  output logic [XLEN-1:0]   ir2_o,
  output logic [XLEN-1:0]   pc2_o
);
  logic            take;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_inc;

  ifu_cond_eval #(.XLEN(XLEN)) u_cond (
    .branch_i (br_class_i),
    .code_i   (cond_code_i),
    .rc_i     (rc_val_i),
    .take_o   (take)
  );

  ifu_pc_reg #(.XLEN(XLEN), .STEP(STEP)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .target_i (rb_val_i),
    .pc_o     (pc),
    .pc_inc_o (pc_inc)
  );

  ifu_ir_stage #(.XLEN(XLEN), .NOP_WORD(NOP_WORD)) u_ir (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en_i (1'b1),
    .word_i    (imem_rdata_i),
    .pc_inc_i  (pc_inc),
    .ir2_o     (ir2_o),
    .pc2_o     (pc2_o)
  );

  assign imem_addr_o = pc;

  assert_always_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_class_i && cond_code_i == CC_ALWAYS) |=>
      imem_addr_o == ($past(rb_val_i) & ~(XLEN'(STEP - 1))));

  assert_never_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code_i == CC_NEVER) |=> imem_addr_o == $past(imem_addr_o) + XLEN'(STEP));

  assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !br_class_i |=> imem_addr_o == $past(imem_addr_o) + XLEN'(STEP));

  assert_slot_pc2_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc2_o == $past(imem_addr_o) + XLEN'(STEP));
endmodule

// File: tb/ifu_top_test.sv
`timescale 1ns/1ps
module ifu_top_test;
  typedef struct packed {
    logic        br;
    logic [2:0]  code;
    logic [31:0] rc;
    logic [31:0] rb;
    logic        taken;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h0000_0000, 32'h0000_0040, 1'b0},  // R7
    '{1'b1, 3'd1, 32'h0000_0005, 32'h0000_0080, 1'b1},  // R8
    '{1'b0, 3'd1, 32'h0000_0000, 32'h0000_0090, 1'b0},  // R6
    '{1'b1, 3'd2, 32'h0000_0000, 32'h0000_0200, 1'b1},  // R9 zero
    '{1'b1, 3'd2, 32'h0000_0001, 32'h0000_0300, 1'b0},  // R9
    '{1'b1, 3'd3, 32'h0000_0000, 32'h0000_0310, 1'b0},  // R9 nonzero
    '{1'b1, 3'd3, 32'h8000_0000, 32'h0000_0340, 1'b1},  // R9
    '{1'b1, 3'd4, 32'h0000_0000, 32'h0000_0400, 1'b1},  // R10 nonneg
    '{1'b1, 3'd4, 32'h8000_0000, 32'h0000_0440, 1'b0},  // R10
    '{1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0000_0500, 1'b1},  // R10 neg
    '{1'b1, 3'd5, 32'h7FFF_FFFF, 32'h0000_0540, 1'b0},  // R10
    '{1'b1, 3'd6, 32'h0000_0000, 32'h0000_0600, 1'b0},  // R11
    '{1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0000_0700, 1'b0},  // R11
    '{1'b0, 3'd2, 32'h0000_0000, 32'h0000_0800, 1'b0},  // R6
    '{1'b1, 3'd1, 32'h0000_0000, 32'h0000_1003, 1'b1}   // R5 unaligned target
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_class_i;
  logic [2:0]  cond_code_i;
  logic [31:0] rc_val_i;
  logic [31:0] rb_val_i;
  logic [31:0] imem_rdata_i;
  logic [31:0] imem_addr_o;
  logic [31:0] ir2_o;
  logic [31:0] pc2_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign imem_rdata_i = mem_word(imem_addr_o);

  ifu_top uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_class_i   (br_class_i),
    .cond_code_i  (cond_code_i),
    .rc_val_i     (rc_val_i),
    .rb_val_i     (rb_val_i),
    .imem_rdata_i (imem_rdata_i),
    .imem_addr_o  (imem_addr_o),
    .ir2_o        (ir2_o),
    .pc2_o        (pc2_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string code_tag(input vec_t v);
    if (!v.br) return "R6";
    case (v.code)
      3'd0:       return "R7";
      3'd1:       return "R8";
      3'd2, 3'd3: return "R9";
      3'd4, 3'd5: return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic step_idle();
    br_class_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pc0;
    logic [31:0] exp_a;
    rst_n = 1'b0;
    br_class_i = 1'b0;
    cond_code_i = 3'd0;
    rc_val_i = '0;
    rb_val_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 addr", imem_addr_o, 32'h0);
    chk("R1 ir2", ir2_o, 32'h0);
    chk("R1 pc2", pc2_o, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 3; i++) begin
      pc0 = imem_addr_o;
      step_idle();
      chk("R3 step", imem_addr_o, pc0 + 32'd4);
      chk("R4 ir2", ir2_o, mem_word(pc0));
      chk("R4 pc2", pc2_o, pc0 + 32'd4);
    end

    for (int i = 0; i < NV; i++) begin
      pc0 = imem_addr_o;
      br_class_i  = VECS[i].br;
      cond_code_i = VECS[i].code;
      rc_val_i    = VECS[i].rc;
      rb_val_i    = VECS[i].rb;
      exp_a = VECS[i].taken ? (VECS[i].rb & ~32'd3) : pc0 + 32'd4;
      @(negedge clk);
      chk(VECS[i].taken ? "R5 target" : code_tag(VECS[i]), imem_addr_o, exp_a);
      chk("R2 aligned", {30'd0, imem_addr_o[1:0]}, 32'h0);
      chk("R4 ir2", ir2_o, mem_word(pc0));
      chk("R4 pc2", pc2_o, pc0 + 32'd4);
      br_class_i = 1'b0;
    end

    // R12 delay slot followed by the target word
    pc0 = imem_addr_o;
    br_class_i = 1'b1; cond_code_i = 3'd1; rb_val_i = 32'h0000_2000;
    @(negedge clk);
    chk("R12 slot ir2", ir2_o, mem_word(pc0));
    chk("R12 slot pc2", pc2_o, pc0 + 32'd4);
    chk("R12 addr", imem_addr_o, 32'h0000_2000);
    step_idle();
    chk("R12 target ir2", ir2_o, mem_word(32'h0000_2000));
    chk("R12 target pc2", pc2_o, 32'h0000_2004);

    // R1 asynchronous reset in mid cycle
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async addr", imem_addr_o, 32'h0);
    chk("R1 async ir2", ir2_o, 32'h0);
    chk("R1 async pc2", pc2_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step_idle();
    chk("R3 after reset", imem_addr_o, 32'h4);
    chk("R4 after reset", ir2_o, mem_word(32'h0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule